// File: doc/BRIEF.md
# PHY Receive Nibble/Bit Deframer

This block sits between an external physical-layer transceiver and a receive MAC. It samples the transceiver's receive lines on the falling edge of the receive clock, picks out the data units that belong to a frame, and packs them into bytes. The MAC receives a byte stream with a valid strobe and a start-of-frame marker on the first byte. When the frame ends, a single end-of-frame pulse carries the frame's status: a bad-frame bit and an alignment-error bit. A separate sticky flag reports whether the transceiver signalled a collision.

Two line formats are supported, and the `serial_mode` input selects one of them. In nibble mode, four data lines carry one nibble per clock. The data-valid line qualifies each nibble, and the error line marks corrupted nibbles. In serial mode, only data line 0 and carrier sense are used: one bit arrives per clock, and carrier sense alone frames the packet. The block does no preamble stripping, no checksum test and no address matching. `serial_mode` is expected to change only between frames.

Top module: `phy_rx_deframer`

## Requirements
- R1: All inputs, including the synchronous active-high `rst`, are sampled on the falling edge of `rx_clk`, and every output changes only at that edge. A byte appears on `out_valid`/`out_byte` in the clock period that follows the falling edge that sampled its last unit.
- R2: In nibble mode, a unit is accepted only at an edge where `rx_crs` and `rx_dv` are both high. At any other edge, `rx_data` has no effect on any output.
- R3: In nibble mode, the first accepted nibble of each byte becomes bits 3:0 and the second becomes bits 7:4.
- R4: In serial mode, one bit is accepted from `rx_data[0]` at each edge where `rx_crs` is high. The first bit is bit 0 of the byte. `rx_data[3:1]`, `rx_dv` and `rx_er` have no effect.
- R5: A frame begins with its first accepted unit. It ends at the first later edge where `rx_crs` is low and `rx_dv` is low (in serial mode, `rx_crs` low alone). `out_eof` then pulses high for exactly one period, once per frame, and never in the same period as `out_valid`. An end condition with no accepted unit since the last end produces no pulse.
- R6: In nibble mode, `out_bad` is high with `out_eof` if and only if `rx_er` was sampled high at any edge from the frame's first accepted unit through its ending edge.
- R7: If a frame ends with a partial byte (an odd nibble count, or a bit count that is not a multiple of 8), `out_align_err` is high with `out_eof` and the partial byte is never output.
- R8: `out_sof` is high together with `out_valid` for the first byte of each frame and for no other byte.
- R9: `col_seen` goes high after any edge that samples `rx_col` high and stays high. At the edge that accepts a new frame's first unit, it takes the value of `rx_col` sampled at that edge.
- R10: After reset, `out_valid`, `out_sof`, `out_eof`, `out_bad`, `out_align_err` and `col_seen` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rx_clk | input | 1 | Receive clock from the transceiver; the block works on its falling edge |
| rst | input | 1 | Synchronous active-high reset |
| serial_mode | input | 1 | 1 selects one-bit serial mode, 0 selects nibble mode |
| rx_crs | input | 1 | Carrier sense |
| rx_dv | input | 1 | Receive data valid (nibble mode only) |
| rx_er | input | 1 | Receive error (nibble mode only) |
| rx_col | input | 1 | Collision detected |
| rx_data | input | 4 | Receive data; only bit 0 is used in serial mode |
| out_valid | output | 1 | A completed byte is on `out_byte` |
| out_byte | output | 8 | Assembled byte |
| out_sof | output | 1 | Marks the first byte of a frame |
| out_eof | output | 1 | One-period end-of-frame status pulse |
| out_bad | output | 1 | Frame contained a receive error; valid with `out_eof` |
| out_align_err | output | 1 | Frame ended on a partial byte; valid with `out_eof` |
| col_seen | output | 1 | Sticky collision flag, reloaded at frame start |

## Verification
A unit counter that drifts by even one step shows up at the ports at once. Bytes then come out with their nibbles swapped, or with the bits rotated, and the alignment flag at the next end-of-frame is wrong. A frame-state bit stuck in the wrong value shows up within one frame as a missing or doubled end pulse, or as a start marker on the wrong byte. A stuck error accumulator appears at the first end pulse as a bad-frame bit that does not match the error line's history. Each of these is visible no later than the end of the frame in which the fault occurs.

// File: rtl/phy_rx_pkg.sv
package phy_rx_pkg;

    localparam int DEF_NIB_W  = 4;
    localparam int DEF_BYTE_W = 8;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RECV = 1'b1
    } rx_state_e;

    // Per-edge qualification of the line inputs.
    typedef struct packed {
        logic accept;     // unit belongs to the frame
        logic frame_end;  // line is idle for framing purposes
        logic err;        // error line counted in this mode
        logic col;        // collision line
    } rx_qual_t;

    // Number of line units that make up one byte.
    function automatic int units_per_byte(input logic serial, input int byte_w, input int nib_w);
        return serial ? byte_w : (byte_w / nib_w);
    endfunction

endpackage

// File: rtl/phy_rx_qual.sv
module phy_rx_qual
    import phy_rx_pkg::*;
(
    input  logic     serial_mode,
    input  logic     rx_crs,
    input  logic     rx_dv,
    input  logic     rx_er,
    input  logic     rx_col,
    output rx_qual_t qual
);
    always_comb begin
        qual.accept    = rx_crs & (serial_mode | rx_dv);
        qual.frame_end = ~rx_crs & (serial_mode | ~rx_dv);
        qual.err       = rx_er & ~serial_mode;
        qual.col       = rx_col;
    end
endmodule

// File: rtl/phy_rx_packer.sv
module phy_rx_packer
    import phy_rx_pkg::*;
#(
    parameter int NIB_W  = DEF_NIB_W,
    parameter int BYTE_W = DEF_BYTE_W
) (
    input  logic              rx_clk,
    input  logic              rst,
    input  logic              serial_mode,
    input  logic              accept,
    input  logic              frame_end,
    input  logic [NIB_W-1:0]  unit,
    output logic              byte_done,
    output logic [BYTE_W-1:0] byte_val,
    output logic              partial
);
    localparam int CNT_W = $clog2(BYTE_W + 1);

    logic [BYTE_W-1:0] shift_q;
    logic [BYTE_W-1:0] shift_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  last_cnt;

    always_comb begin
        last_cnt = CNT_W'(units_per_byte(serial_mode, BYTE_W, NIB_W) - 1);
        if (serial_mode)
            shift_d = {unit[0], shift_q[BYTE_W-1:1]};
        else
            shift_d = {unit, shift_q[BYTE_W-1:NIB_W]};
    end

    assign byte_done = accept & (cnt_q == last_cnt);
    assign byte_val  = shift_d;
    assign partial   = (cnt_q != '0);

    always_ff @(negedge rx_clk) begin
        if (rst) begin
            shift_q <= '0;
            cnt_q   <= '0;
        end else if (frame_end) begin
            cnt_q   <= '0;
        end else if (accept) begin
            shift_q <= shift_d;
            cnt_q   <= byte_done ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/phy_rx_framer.sv
module phy_rx_framer
    import phy_rx_pkg::*;
(
    input  logic     rx_clk,
    input  logic     rst,
    input  rx_qual_t qual,
    input  logic     partial,
    input  logic     byte_done,
    output logic     first_byte,
    output logic     eof_q,
    output logic     bad_q,
    output logic     align_q,
    output logic     col_q
);
    rx_state_e state_q;
    logic      err_q;
    logic      sof_pend_q;
    logic      start;
    logic      finish;

    assign start      = qual.accept & (state_q == ST_IDLE);
    assign finish     = qual.frame_end & (state_q == ST_RECV);
    assign first_byte = start | sof_pend_q;

    always_ff @(negedge rx_clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            err_q      <= 1'b0;
            sof_pend_q <= 1'b0;
            eof_q      <= 1'b0;
            bad_q      <= 1'b0;
            align_q    <= 1'b0;
            col_q      <= 1'b0;
        end else begin
            eof_q   <= finish;
            bad_q   <= finish & (err_q | qual.err);
            align_q <= finish & partial;

            if (start)
                state_q <= ST_RECV;
            else if (finish)
                state_q <= ST_IDLE;

            if (start)
                err_q <= qual.err;
            else if (finish)
                err_q <= 1'b0;
            else if (state_q == ST_RECV && qual.err)
                err_q <= 1'b1;

            if (byte_done || finish)
                sof_pend_q <= 1'b0;
            else if (start)
                sof_pend_q <= 1'b1;

            if (start)
                col_q <= qual.col;
            else if (qual.col)
                col_q <= 1'b1;
        end
    end
endmodule

// File: rtl/phy_rx_deframer.sv
module phy_rx_deframer
    import phy_rx_pkg::*;
#(
    parameter int NIB_W  = DEF_NIB_W,
    parameter int BYTE_W = DEF_BYTE_W
) (
    input  logic              rx_clk,
    input  logic              rst,
    input  logic              serial_mode,
    input  logic              rx_crs,
    input  logic              rx_dv,
    input  logic              rx_er,
    input  logic              rx_col,
    input  logic [NIB_W-1:0]  rx_data,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_byte,
    output logic              out_sof,
    output logic              out_eof,
    output logic              out_bad,
    output logic              out_align_err,
    output logic              col_seen
);
    rx_qual_t          qual;
    logic              byte_done;
    logic [BYTE_W-1:0] byte_val;
    logic              partial;
    logic              first_byte;

    phy_rx_qual u_qual (
        .serial_mode (serial_mode),
        .rx_crs      (rx_crs),
        .rx_dv       (rx_dv),
        .rx_er       (rx_er),
        .rx_col      (rx_col),
        .qual        (qual)
    );

    phy_rx_packer #(.NIB_W(NIB_W), .BYTE_W(BYTE_W)) u_packer (
        .rx_clk      (rx_clk),
        .rst         (rst),
        .serial_mode (serial_mode),
        .accept      (qual.accept),
        .frame_end   (qual.frame_end),
        .unit        (rx_data),
        .byte_done   (byte_done),
        .byte_val    (byte_val),
        .partial     (partial)
    );

    phy_rx_framer u_framer (
        .rx_clk     (rx_clk),
        .rst        (rst),
        .qual       (qual),
        .partial    (partial),
        .byte_done  (byte_done),
        .first_byte (first_byte),
        .eof_q      (out_eof),
        .bad_q      (out_bad),
        .align_q    (out_align_err),
        .col_q      (col_seen)
    );

    always_ff @(negedge rx_clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_sof   <= 1'b0;
            out_byte  <= '0;
        end else begin
            out_valid <= byte_done;
            out_sof   <= byte_done & first_byte;
            if (byte_done)
                out_byte <= byte_val;
        end
    end
endmodule

// File: rtl/phy_rx_deframer_chk.sv
module phy_rx_deframer_chk #(
    parameter int NIB_W  = 4,
    parameter int BYTE_W = 8
) (
    input logic              rx_clk,
    input logic              rst,
    input logic              serial_mode,
    input logic              rx_crs,
    input logic              rx_dv,
    input logic              rx_er,
    input logic              rx_col,
    input logic [NIB_W-1:0]  rx_data,
    input logic              out_valid,
    input logic [BYTE_W-1:0] out_byte,
    input logic              out_sof,
    input logic              out_eof,
    input logic              out_bad,
    input logic              out_align_err,
    input logic              col_seen
);
    // R2: a byte can only follow an edge that accepted a unit
    a_r2_valid_after_accept: assert property (@(negedge rx_clk) disable iff (rst)
        out_valid |-> ($past(rx_crs) && ($past(rx_dv) || $past(serial_mode))));

    // R5: end pulse lasts one period and never coincides with a byte
    a_r5_eof_one_period: assert property (@(negedge rx_clk) disable iff (rst)
        out_eof |=> !out_eof);
    a_r5_eof_not_with_valid: assert property (@(negedge rx_clk) disable iff (rst)
        !(out_eof && out_valid));

    // R6: bad status only rides on the end pulse
    a_r6_bad_with_eof: assert property (@(negedge rx_clk) disable iff (rst)
        out_bad |-> out_eof);

    // R7: alignment status only rides on the end pulse
    a_r7_align_with_eof: assert property (@(negedge rx_clk) disable iff (rst)
        out_align_err |-> out_eof);

    // R8: start marker only on a byte
    a_r8_sof_with_valid: assert property (@(negedge rx_clk) disable iff (rst)
        out_sof |-> out_valid);

    // R9: collision flag rises only after a sampled collision
    a_r9_col_rise: assert property (@(negedge rx_clk) disable iff (rst)
        $rose(col_seen) |-> $past(rx_col));
endmodule

bind phy_rx_deframer phy_rx_deframer_chk #(.NIB_W(NIB_W), .BYTE_W(BYTE_W)) u_chk (.*);

// File: tb/phy_rx_deframer_tb.sv
`timescale 1ns/1ps
module phy_rx_deframer_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mode = 1'b0;
    logic       crs = 1'b0, dv = 1'b0, er = 1'b0, col = 1'b0;
    logic [3:0] data = 4'h0;
    logic       out_valid, out_sof, out_eof, out_bad, out_align_err, col_seen;
    logic [7:0] out_byte;

    int checks = 0;
    int errors = 0;

    // reference model state
    bit       m_in, m_first, m_err, m_col;
    int       m_cnt;
    bit [7:0] m_sh;
    bit       e_valid, e_sof, e_eof, e_bad, e_al;
    bit [7:0] e_byte;

    always #2.5 clk = ~clk;

    phy_rx_deframer u_dut (
        .rx_clk(clk), .rst(rst), .serial_mode(mode),
        .rx_crs(crs), .rx_dv(dv), .rx_er(er), .rx_col(col), .rx_data(data),
        .out_valid(out_valid), .out_byte(out_byte), .out_sof(out_sof),
        .out_eof(out_eof), .out_bad(out_bad), .out_align_err(out_align_err),
        .col_seen(col_seen)
    );

    task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic model(input bit s, input bit c, input bit v, input bit e, input bit k, input bit [3:0] d);
        bit acc, fin, started;
        acc = c && (s || v);
        fin = !c && (s || !v);
        started = 1'b0;
        e_valid = 0; e_sof = 0; e_eof = 0; e_bad = 0; e_al = 0;
        if (acc) begin
            if (!m_in) begin
                m_in = 1; m_first = 1; m_err = 0; m_cnt = 0; started = 1;
            end
            if (s) m_sh = {d[0], m_sh[7:1]};
            else   m_sh = {d, m_sh[7:4]};
            m_cnt++;
            if (m_cnt == (s ? 8 : 2)) begin
                e_valid = 1; e_byte = m_sh; e_sof = m_first; m_first = 0; m_cnt = 0;
            end
        end
        if (!s && e && m_in) m_err = 1;
        if (fin && m_in) begin
            e_eof = 1; e_bad = m_err; e_al = (m_cnt != 0);
            m_in = 0; m_cnt = 0; m_err = 0;
        end
        if (started) m_col = k;
        else if (k) m_col = 1;
    endtask

    // drive one unit, wait past the sampling edge, compare all outputs
    task automatic step(input bit c, input bit v, input bit e, input bit k, input bit [3:0] d);
        crs = c; dv = v; er = e; col = k; data = d;
        @(posedge clk);
        model(mode, c, v, e, k, d);
        chk("R1,R2", "out_valid", {7'd0, out_valid}, {7'd0, e_valid});
        if (e_valid) chk(mode ? "R4" : "R3", "out_byte", out_byte, e_byte);
        chk("R8", "out_sof", {7'd0, out_sof}, {7'd0, e_sof});
        chk("R5", "out_eof", {7'd0, out_eof}, {7'd0, e_eof});
        chk("R6", "out_bad", {7'd0, out_bad}, {7'd0, e_bad});
        chk("R7", "out_align_err", {7'd0, out_align_err}, {7'd0, e_al});
        chk("R9", "col_seen", {7'd0, col_seen}, {7'd0, m_col});
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, $urandom % 2, 0, 4'($urandom));
    endtask

    // nibble-mode frame; er_at / gap_at / col_at select a unit index, -1 for none
    task automatic mii_frame(input int n, input int er_at, input int gap_at, input int col_at);
        mode = 0;
        for (int i = 0; i < n; i++) begin
            if (i == gap_at) step(1, 0, 0, 0, 4'($urandom));
            step(1, 1, i == er_at, i == col_at, 4'($urandom));
        end
        step(0, 0, 0, 0, 4'($urandom));
    endtask

    // serial frame with noise on the unused lines (R4)
    task automatic ser_frame(input int n, input int col_at);
        mode = 1;
        for (int i = 0; i < n; i++)
            step(1, $urandom % 2, $urandom % 2, i == col_at, 4'($urandom));
        step(0, $urandom % 2, $urandom % 2, 0, 4'($urandom));
    endtask

    initial begin
        #(900_000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 4; i++) begin
            crs = 1; dv = 1; er = 1; col = 1; data = 4'hF;
            @(posedge clk);
        end
        rst = 0; crs = 0; dv = 0; er = 0; col = 0;
        @(posedge clk);
        // R10: reset state
        chk("R10", "out_valid", {7'd0, out_valid}, 8'd0);
        chk("R10", "out_sof", {7'd0, out_sof}, 8'd0);
        chk("R10", "out_eof", {7'd0, out_eof}, 8'd0);
        chk("R10", "out_bad", {7'd0, out_bad}, 8'd0);
        chk("R10", "out_align_err", {7'd0, out_align_err}, 8'd0);
        chk("R10", "col_seen", {7'd0, col_seen}, 8'd0);

        // R2: junk on data with dv low, including carrier without valid
        idle(3);
        step(1, 0, 0, 0, 4'hA); step(1, 0, 0, 0, 4'h5); step(0, 0, 0, 0, 4'h3);
        // R3: known byte order, low nibble first -> 0x5A
        mode = 0;
        step(1, 1, 0, 0, 4'hA); step(1, 1, 0, 0, 4'h5); step(0, 0, 0, 0, 4'h0);
        chk("R3", "directed byte 0x5A held", out_byte, 8'h5A);
        idle(2);
        mii_frame(8, -1, -1, -1);     // clean
        mii_frame(8, 3, -1, -1);      // R6 error mid-frame
        mii_frame(6, 0, -1, -1);      // R6 error on first nibble
        mii_frame(7, -1, -1, -1);     // R7 odd nibbles
        mii_frame(1, -1, -1, -1);     // R7 single nibble, no byte
        mii_frame(10, -1, 4, -1);     // R2 dv gap inside carrier
        mii_frame(6, -1, -1, 2);      // R9 collision
        mii_frame(4, -1, -1, 0);      // R9 collision at frame start
        idle(2);
        ser_frame(16, -1);            // R4 two bytes
        ser_frame(11, -1);            // R7 partial serial byte
        ser_frame(8, 3);              // R9 serial collision
        idle(2);

        for (int f = 0; f < 150; f++) begin
            idle(1 + $urandom % 3);
            if ($urandom % 2) begin
                mode = 0;
                for (int i = 0, n = 1 + $urandom % 40; i < n; i++) begin
                    if ($urandom % 10 == 0) step(1, 0, $urandom % 2, 0, 4'($urandom));
                    step(1, 1, ($urandom % 30) == 0, ($urandom % 25) == 0, 4'($urandom));
                end
                step(0, 0, ($urandom % 10) == 0, 0, 4'($urandom));
            end else begin
                ser_frame(1 + $urandom % 80, ($urandom % 4 == 0) ? int'($urandom % 8) : -1);
            end
        end
        idle(3);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule